// File: doc/BRIEF.md
# Interrupt Request and Service Core

This block sits between eight interrupt request lines and one interrupt output toward a processor or an upstream controller. Each request input is synchronized. It is then captured either on its rising edge or as a level, and the result is stored in a pending register. Lines that are masked are refused at capture.

A second register records which lines are in service. The interrupt output is a registered level. It is raised when the highest pending line has no in-service bit at its own position or at any higher position. Priority is fixed, and the higher line number wins.

When the acknowledge strobe arrives, the block picks the winner and clears its pending bit. It either marks the line in service or, in auto-EOI mode, skips that step. In the same cycle it drives an 8-bit vector. The vector is formed from the base upper bits and the line number. If the winning line is marked in the cascade map and a downstream controller is present, the block instead pulses a slave-acknowledge strobe and passes the slave's vector through. The slave-acknowledge strobe is meant to drive the slave's own acknowledge input.

An end-of-interrupt strobe clears the in-service bit of the line it names. The output is then re-evaluated. There is no back-pressure anywhere: acknowledge and EOI are single-cycle strobes, and the vector is valid only during the acknowledge cycle.

Top module: `irq_service_core`

## Requirements
- R1: After reset, the pending register, the in-service register and the interrupt output are all zero.
- R2: A request on a line whose mask bit is 1 does not set that line's pending bit.
- R3: In edge mode (edge_mode=1), a rising edge on a line sets its pending bit. The bit persists after the input drops. An input still held high after acknowledge does not set the bit again.
- R4: In level mode (edge_mode=0), the pending bit follows the synchronized input: it is set while the input is high and cleared when the input goes low.
- R5: The interrupt output goes high only when a line is pending and no in-service bit is set at or above the highest pending line number.
- R6: On acknowledge, the highest-numbered pending line wins.
- R7: On acknowledge without auto-EOI, the winner's pending bit clears and its in-service bit sets. The vector is {vec_base[7:3], line[2:0]}.
- R8: On acknowledge with auto_eoi=1, the winner's pending bit clears and no in-service bit is set.
- R9: An EOI strobe clears the in-service bit of eoi_line. A pending line that was blocked raises the output two cycles later.
- R10: The interrupt output is low in the cycle after an acknowledge. It is re-evaluated in the cycle after that.
- R11: When slave_present=1 and the cascade_map bit of the winning line is 1, slave_ack pulses in the acknowledge cycle and vec_out equals slave_vec. Otherwise slave_ack stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| irq_in | input | 8 | Asynchronous request lines |
| mask | input | 8 | 1 blocks capture on that line |
| edge_mode | input | 1 | 1 = rising-edge capture, 0 = level capture |
| vec_base | input | 8 | Vector base; only bits 7:3 are used |
| cascade_map | input | 8 | Lines whose vector comes from a slave |
| slave_present | input | 1 | A slave controller is attached |
| auto_eoi | input | 1 | Acknowledge ends service at once |
| eoi_valid | input | 1 | End-of-interrupt strobe |
| eoi_line | input | 3 | Line whose service ends |
| ack | input | 1 | Acknowledge strobe |
| slave_vec | input | 8 | Vector returned by the slave |
| int_out | output | 1 | Registered interrupt request |
| vec_out | output | 8 | Vector, valid while ack is high |
| slave_ack | output | 1 | Acknowledge forwarded to the slave |
| req_reg | output | 8 | Pending register readback |
| insvc_reg | output | 8 | In-service register readback |

## Verification
A table of request patterns combined with masks exercises single lines, the two extreme lines together, several lines where the top one is masked, and fully masked inputs. Together these separate mask handling from priority choice and from vector formation.

Directed sequences leave a higher line in service while lower lines request, which shows that the output is gated rather than merely wired to the pending bits. They also end service in both orders to expose the re-evaluation. A line held high across an acknowledge tells edge capture apart from level capture. A second instance, chained as a slave on line 2, shows that the vector comes from the slave only for mapped lines.

// File: rtl/irq_core_pkg.sv
package irq_core_pkg;
  typedef enum logic {
    CAPT_LEVEL = 1'b0,
    CAPT_EDGE  = 1'b1
  } capt_mode_e;
endpackage

// File: rtl/irq_sync_detect.sv
module irq_sync_detect #(
  parameter int NUM_LINES   = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_LINES-1:0] irq_in,
  input  logic                 edge_mode,
  output logic [NUM_LINES-1:0] set_req,
  output logic [NUM_LINES-1:0] sync_lvl
);
  import irq_core_pkg::*;

  logic [NUM_LINES-1:0] prev_lvl;

  for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
    logic [SYNC_STAGES:0] shreg;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) shreg <= '0;
      else        shreg <= {shreg[SYNC_STAGES-1:0], irq_in[g]};
    end
    assign sync_lvl[g] = shreg[SYNC_STAGES-1];
    assign prev_lvl[g] = shreg[SYNC_STAGES];
  end

  always_comb begin
    if (capt_mode_e'(edge_mode) == CAPT_EDGE) set_req = sync_lvl & ~prev_lvl;
    else                                      set_req = sync_lvl;
  end
endmodule

// File: rtl/irq_prio_pick.sv
module irq_prio_pick #(
  parameter int NUM_LINES = 8,
  localparam int IDX_W    = $clog2(NUM_LINES)
) (
  input  logic [NUM_LINES-1:0] req,
  output logic                 any,
  output logic [IDX_W-1:0]     idx,
  output logic [NUM_LINES-1:0] onehot
);
  always_comb begin
    idx    = '0;
    onehot = '0;
    any    = |req;
    for (int i = 0; i < NUM_LINES; i++) begin
      if (req[i]) idx = IDX_W'(i);
    end
    if (any) onehot[idx] = 1'b1;
  end
endmodule

// File: rtl/irq_service_core.sv
module irq_service_core #(
  parameter int NUM_LINES   = 8,
  parameter int VEC_W       = 8,
  parameter int SYNC_STAGES = 2,
  localparam int IDX_W      = $clog2(NUM_LINES)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_LINES-1:0] irq_in,
  input  logic [NUM_LINES-1:0] mask,
  input  logic                 edge_mode,
  input  logic [VEC_W-1:0]     vec_base,
  input  logic [NUM_LINES-1:0] cascade_map,
  input  logic                 slave_present,
  input  logic                 auto_eoi,
  input  logic                 eoi_valid,
  input  logic [IDX_W-1:0]     eoi_line,
  input  logic                 ack,
  input  logic [VEC_W-1:0]     slave_vec,
  output logic                 int_out,
  output logic [VEC_W-1:0]     vec_out,
  output logic                 slave_ack,
  output logic [NUM_LINES-1:0] req_reg,
  output logic [NUM_LINES-1:0] insvc_reg
);
  localparam logic [NUM_LINES-1:0] ONE = {{(NUM_LINES-1){1'b0}}, 1'b1};

  logic [NUM_LINES-1:0] set_req, sync_lvl;
  logic [NUM_LINES-1:0] req_q, req_n, insvc_q, insvc_n;
  logic [NUM_LINES-1:0] win_oh, eoi_oh, ack_clr, lvl_clr;
  logic [IDX_W-1:0]     win_idx;
  logic                 any_req, accept, gate_ok, int_q, int_n;

  irq_sync_detect #(.NUM_LINES(NUM_LINES), .SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .edge_mode(edge_mode),
    .set_req(set_req), .sync_lvl(sync_lvl)
  );

  irq_prio_pick #(.NUM_LINES(NUM_LINES)) u_pick (
    .req(req_q), .any(any_req), .idx(win_idx), .onehot(win_oh)
  );

  always_comb begin
    accept  = ack && any_req;
    ack_clr = accept ? win_oh : '0;
    lvl_clr = edge_mode ? '0 : ~sync_lvl;
    req_n   = (req_q | (set_req & ~mask)) & ~ack_clr & ~lvl_clr;
    eoi_oh  = eoi_valid ? (ONE << eoi_line) : '0;
    insvc_n = (insvc_q & ~eoi_oh) | ((accept && !auto_eoi) ? win_oh : '0);
    gate_ok = (insvc_q >> win_idx) == '0;
    int_n   = !ack && any_req && gate_ok;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q   <= '0;
      insvc_q <= '0;
      int_q   <= 1'b0;
    end else begin
      req_q   <= req_n;
      insvc_q <= insvc_n;
      int_q   <= int_n;
    end
  end

  assign slave_ack = accept && slave_present && cascade_map[win_idx];
  assign vec_out   = slave_ack ? slave_vec : {vec_base[VEC_W-1:IDX_W], win_idx};
  assign int_out   = int_q;
  assign req_reg   = req_q;
  assign insvc_reg = insvc_q;

  // R10: output is low right after an acknowledge
  a_r10_drop_after_ack: assert property (@(posedge clk) disable iff (!rst_n)
    ack |=> !int_out);

  // R6: a direct vector names the highest pending line
  a_r6_highest_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && any_req && !slave_ack) |->
      (req_q[vec_out[IDX_W-1:0]] && ((req_q >> vec_out[IDX_W-1:0]) == ONE)));

  // R7: a normal acknowledge leaves the winner in service
  a_r7_insvc_set: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && any_req && !auto_eoi) |=> ((insvc_q & $past(win_oh)) != '0));

  // R11: forwarding only on an acknowledge with a slave present
  a_r11_slave_ack_gate: assert property (@(posedge clk) disable iff (!rst_n)
    slave_ack |-> (ack && slave_present));

  // R9: end of interrupt clears the named bit unless re-set by acknowledge
  a_r9_eoi_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (eoi_valid && !(ack && any_req && !auto_eoi && win_idx == eoi_line)) |=>
      !insvc_q[$past(eoi_line)]);

  // R2: a pending bit never appears on a line that was masked
  a_r2_mask_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((req_q & ~$past(req_q) & $past(mask)) == '0));
endmodule

// File: tb/tb_irq_service_core.sv
`timescale 1ns/1ps
module tb_irq_service_core;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  int tests = 0;
  int fails = 0;
  bit done = 1'b0;

  logic [7:0] m_irq = '0, m_mask = '0, s_irq = '0;
  logic       m_edge = 1'b1, m_auto = 1'b0, m_eoi = 1'b0, m_ack = 1'b0;
  logic [2:0] m_eoi_line = '0;
  logic       m_int, m_sack, s_int, s_sack;
  logic [7:0] m_vec, m_req, m_ins, s_vec, s_req, s_ins, m_irq_in;

  assign m_irq_in = {m_irq[7:3], s_int, m_irq[1:0]};

  irq_service_core dut (
    .clk(clk), .rst_n(rst_n), .irq_in(m_irq_in), .mask(m_mask), .edge_mode(m_edge),
    .vec_base(8'h20), .cascade_map(8'h04), .slave_present(1'b1), .auto_eoi(m_auto),
    .eoi_valid(m_eoi), .eoi_line(m_eoi_line), .ack(m_ack), .slave_vec(s_vec),
    .int_out(m_int), .vec_out(m_vec), .slave_ack(m_sack), .req_reg(m_req), .insvc_reg(m_ins)
  );

  irq_service_core u_slave (
    .clk(clk), .rst_n(rst_n), .irq_in(s_irq), .mask(8'h00), .edge_mode(1'b1),
    .vec_base(8'h28), .cascade_map(8'h00), .slave_present(1'b0), .auto_eoi(1'b0),
    .eoi_valid(1'b0), .eoi_line(3'd0), .ack(m_sack), .slave_vec(8'h00),
    .int_out(s_int), .vec_out(s_vec), .slave_ack(s_sack), .req_reg(s_req), .insvc_reg(s_ins)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    m_irq = '0; s_irq = '0; m_ack = 1'b0; m_eoi = 1'b0;
    wait_n(2);
    rst_n = 1'b1;
    wait_n(1);
  endtask

  task automatic pulse(input logic [7:0] lines);
    m_irq = lines;
    wait_n(2);
    m_irq = '0;
    wait_n(4);
  endtask

  // acknowledge for one cycle; vector checked while ack is high
  task automatic do_ack(input string tag, input logic [7:0] exp_vec);
    m_ack = 1'b1;
    #1;
    chk(tag, m_vec, exp_vec);
    @(negedge clk);
    m_ack = 1'b0;
  endtask

  task automatic do_eoi(input logic [2:0] line);
    m_eoi = 1'b1; m_eoi_line = line;
    @(negedge clk);
    m_eoi = 1'b0;
  endtask

  // {irq[39:32], mask[31:24], vec[23:16], insvc[15:8], int[0]}
  localparam logic [39:0] TBL [5] = '{
    {8'h01, 8'h00, 8'h20, 8'h01, 8'h01},
    {8'h81, 8'h00, 8'h27, 8'h80, 8'h01},
    {8'h38, 8'h20, 8'h24, 8'h10, 8'h01},
    {8'h0B, 8'h0B, 8'h00, 8'h00, 8'h00},
    {8'h50, 8'h40, 8'h24, 8'h10, 8'h01}
  };

  initial begin
    #400000;
    fails++;
    $display("FAIL watchdog: actual hung expected done");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    do_reset();
    chk("R1 req", m_req, 8'h00);
    chk("R1 insvc", m_ins, 8'h00);
    chk("R1 int", m_int, 1'b0);

    for (int k = 0; k < 5; k++) begin
      do_reset();
      m_mask = TBL[k][31:24];
      pulse(TBL[k][39:32]);
      chk("R2/R3 req", m_req, TBL[k][39:32] & ~TBL[k][31:24]);
      chk("R5 int", m_int, TBL[k][0]);
      if (TBL[k][0]) begin
        do_ack("R6/R7 vec", TBL[k][23:16]);
        chk("R11 no fwd", m_sack, 1'b0);
        chk("R7 insvc", m_ins, TBL[k][15:8]);
        chk("R10 int low", m_int, 1'b0);
      end
      m_mask = '0;
    end

    // R3: held input does not re-request after acknowledge
    do_reset();
    m_irq = 8'h10;
    wait_n(5);
    do_ack("R3 vec", 8'h24);
    wait_n(5);
    chk("R3 held no re-set", m_req, 8'h00);
    m_irq = '0;

    // R4: level capture follows input
    do_reset();
    m_edge = 1'b0;
    m_irq = 8'h20;
    wait_n(5);
    chk("R4 level set", m_req, 8'h20);
    m_irq = '0;
    wait_n(4);
    chk("R4 level clear", m_req, 8'h00);
    m_edge = 1'b1;

    // R5 / R9: gating by in-service lines
    do_reset();
    pulse(8'h08);
    do_ack("R7 vec3", 8'h23);
    pulse(8'h02);
    chk("R5 pending below", m_req, 8'h02);
    chk("R5 gated", m_int, 1'b0);
    pulse(8'h40);
    chk("R5 higher raises", m_int, 1'b1);
    do_ack("R6 vec6", 8'h26);
    chk("R7 insvc two", m_ins, 8'h48);
    do_eoi(3'd6);
    wait_n(1);
    chk("R9 still gated", m_int, 1'b0);
    chk("R9 clear6", m_ins, 8'h08);
    do_eoi(3'd3);
    wait_n(1);
    chk("R9 re-raise", m_int, 1'b1);
    chk("R9 clear3", m_ins, 8'h00);

    // R8 / R10: auto end of interrupt, drop then re-evaluate
    do_reset();
    m_auto = 1'b1;
    pulse(8'h30);
    do_ack("R8 vec", 8'h25);
    chk("R10 low after ack", m_int, 1'b0);
    chk("R8 no insvc", m_ins, 8'h00);
    wait_n(1);
    chk("R10 re-raised", m_int, 1'b1);
    chk("R8 req left", m_req, 8'h10);
    m_auto = 1'b0;

    // R11: vector from the slave on line 2
    do_reset();
    s_irq = 8'h08;
    wait_n(2);
    s_irq = '0;
    wait_n(10);
    chk("R11 master int", m_int, 1'b1);
    m_ack = 1'b1;
    #1;
    chk("R11 slave_ack", m_sack, 1'b1);
    chk("R11 vec", m_vec, 8'h2B);
    @(negedge clk);
    m_ack = 1'b0;
    chk("R11 master insvc", m_ins, 8'h04);
    chk("R11 slave insvc", s_ins, 8'h08);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule